// File: doc/BRIEF.md
# SDRAM Auto-Refresh and Mode-Set Sequencer

This block drives the command pins of an SDRAM (chip select, RAS, CAS, write enable and the row address bus). It does two jobs. It programs the memory's mode register once the controller has been configured, and it keeps the array alive with periodic auto-refresh commands. The host first writes the configuration, which sets a 16-bit refresh interval and a row-cycle hold time. The host then writes to a reserved address window. The low twelve address bits of that write are the mode value, and the write carries no data. A supported value produces one mode-set command. An unsupported value, or a write made before any configuration, produces no command and sets a sticky error flag.

Once the memory is ready, the interval timer raises a refresh request every interval. The request is held in a single slot. It waits while a host bus cycle is in progress and while a previous refresh is still inside its row-cycle hold. If a second request arrives before the first one is served, the two merge into one request and a sticky overrun flag is set. Host accesses are told to wait through `host_stall` for four reasons: the memory is not ready, a refresh is pending, a refresh is holding the bus, or the mode-set recovery is running.

Top module: `sdram_refresh_seq`

## Requirements
- R1: After reset all four command pins are high (deselect), `sd_addr` is 0, `sdram_ready`, `refresh_overrun` and `mode_error` are 0, and `host_stall` is 1.
- R2: A window write made before any `cfg_wr` issues no command. It sets `mode_error`, visible in the next cycle.
- R3: The window is every `host_addr` whose bits [23:12] equal 12'hFFF. A valid window write after configuration drives the mode-set command (cs, ras, cas and we all low) in the next cycle. In that cycle `sd_addr[11:0]` carries address bits [11:0] and `sd_addr[12]` is 0.
- R4: A mode value is valid only if all of these hold: bits [2:0]=000, bit 3=0, bits [6:4] are 2 or 3, bits [8:7]=00 and bits [11:10]=00. Bit 9 may be 0 or 1. An invalid value issues no command and sets the sticky `mode_error`.
- R5: `sdram_ready` drops in the mode-set cycle and rises two cycles after it. `host_stall` is high whenever `sdram_ready` is low.
- R6: While ready and with a nonzero interval N, a refresh request is raised every N cycles. With no host traffic, refresh commands therefore come exactly N cycles apart. An interval of 0 produces no refresh.
- R7: A refresh command is cs, ras and cas low with we high. It appears in the cycle after a request is pending, provided `host_cyc` is low, no hold is running and no mode-set is launching. While `host_cyc` is high the command is deferred.
- R8: From the refresh cycle, `host_stall` stays high for exactly tRC cycles and no other command is issued in that time. tRC is `cfg_trc` clamped to the range 4..15.
- R9: A request that arrives while one is still pending sets the sticky `refresh_overrun`, and only one refresh is served for the merged requests.
- R10: A host write outside the window issues no command and changes neither flag nor ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_interval | input | 16 | Refresh interval in cycles, 0 disables |
| cfg_trc | input | 4 | Row-cycle hold after refresh, clamped to 4..15 |
| host_wr | input | 1 | Host write strobe, one cycle per write |
| host_addr | input | 24 | Host write address |
| host_cyc | input | 1 | High while a host bus cycle is in progress |
| sd_cs_n | output | 1 | SDRAM chip select, active low |
| sd_ras_n | output | 1 | SDRAM row strobe, active low |
| sd_cas_n | output | 1 | SDRAM column strobe, active low |
| sd_we_n | output | 1 | SDRAM write enable, active low |
| sd_addr | output | 13 | SDRAM address pins |
| sdram_ready | output | 1 | Memory initialised and usable |
| host_stall | output | 1 | Host must not start an access |
| refresh_overrun | output | 1 | Sticky: a pending refresh request was overwritten |
| mode_error | output | 1 | Sticky: a mode write was rejected |

## Verification
Every output is registered, so each result can be timed from the edge that acts on the input:
- A window write in one cycle shows its command or its error in the next cycle.
- `sdram_ready` follows a mode-set command by two cycles.
- A refresh request raised at an edge is visible in the following cycle, and the command appears one cycle after that if the bus is free.
- The stall window runs for tRC cycles, starting with the command cycle.

The bench keeps a behavioural model and steps it at each rising edge using the inputs it drives at falling edges. It compares every output at the next falling edge. Directed checks then measure refresh spacing, stall length and the number of commands served, by counting cycles from the command cycles seen at the pins.

// File: rtl/sdram_refresh_seq.sv
module sdram_refresh_seq #(
  parameter int ADDR_W    = 24,
  parameter int ROW_W     = 13,
  parameter int INTV_W    = 16,
  parameter int TRC_W     = 4,
  parameter int TRC_MIN   = 4,
  parameter int TMRD      = 2,
  parameter logic [ADDR_W-1:0] MODE_BASE = 24'hFFF000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [INTV_W-1:0] cfg_interval,
  input  logic [TRC_W-1:0]  cfg_trc,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_cyc,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [ROW_W-1:0]  sd_addr,
  output logic              sdram_ready,
  output logic              host_stall,
  output logic              refresh_overrun,
  output logic              mode_error
);
  localparam int MV_W  = 12;
  localparam int MRD_W = $clog2(TMRD + 1);
  localparam logic [3:0] CMD_DESEL = 4'b1111;
  localparam logic [3:0] CMD_REF   = 4'b0001;
  localparam logic [3:0] CMD_MRS   = 4'b0000;

  logic              cfg_done;
  logic [INTV_W-1:0] intv, tcnt;
  logic [TRC_W-1:0]  trc_q, hold;
  logic [MRD_W-1:0]  mrd;
  logic              pend;
  logic [3:0]        cmd_q;
  logic [ROW_W-1:0]  addr_q;

  logic [MV_W-1:0] mval;
  logic in_win, mval_ok, mrs_go, mrs_bad, tick, ref_go;
  logic [TRC_W-1:0] trc_eff;

  assign mval    = host_addr[MV_W-1:0];
  assign in_win  = host_wr && (host_addr[ADDR_W-1:MV_W] == MODE_BASE[ADDR_W-1:MV_W]);
  assign mval_ok = (mval[3:0] == 4'd0) && (mval[6:4] == 3'd2 || mval[6:4] == 3'd3)
                 && (mval[8:7] == 2'd0) && (mval[11:10] == 2'd0);
  assign mrs_go  = in_win && cfg_done && mval_ok;
  assign mrs_bad = in_win && !(cfg_done && mval_ok);
  assign tick    = sdram_ready && (intv != '0) && (tcnt == intv - 1'b1);
  assign ref_go  = pend && sdram_ready && !host_cyc && (hold == '0) && !mrs_go;
  assign trc_eff = (cfg_trc < TRC_W'(TRC_MIN)) ? TRC_W'(TRC_MIN) : cfg_trc;

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;
  assign sd_addr    = addr_q;
  assign host_stall = !sdram_ready || (hold != '0) || pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_done <= 1'b0;
      intv     <= '0;
      trc_q    <= TRC_W'(TRC_MIN);
    end else if (cfg_wr) begin
      cfg_done <= 1'b1;
      intv     <= cfg_interval;
      trc_q    <= trc_eff;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        tcnt <= '0;
    else if (cfg_wr || tick)           tcnt <= '0;
    else if (sdram_ready && intv != 0) tcnt <= tcnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend            <= 1'b0;
      refresh_overrun <= 1'b0;
    end else begin
      if (tick) pend <= 1'b1;
      else if (ref_go) pend <= 1'b0;
      if (tick && pend && !ref_go) refresh_overrun <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             hold <= '0;
    else if (ref_go)        hold <= trc_q;
    else if (hold != '0)    hold <= hold - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mrd         <= '0;
      sdram_ready <= 1'b0;
      mode_error  <= 1'b0;
    end else begin
      if (mrs_bad) mode_error <= 1'b1;
      if (mrs_go) begin
        mrd         <= MRD_W'(TMRD);
        sdram_ready <= 1'b0;
      end else if (mrd != '0) begin
        mrd <= mrd - 1'b1;
        if (mrd == MRD_W'(1)) sdram_ready <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= CMD_DESEL;
      addr_q <= '0;
    end else if (mrs_go) begin
      cmd_q  <= CMD_MRS;
      addr_q <= ROW_W'(mval);
    end else if (ref_go) begin
      cmd_q  <= CMD_REF;
      addr_q <= '0;
    end else begin
      cmd_q  <= CMD_DESEL;
      addr_q <= '0;
    end
  end
endmodule

// File: rtl/sdram_refresh_seq_chk.sv
module sdram_refresh_seq_chk #(
  parameter int ROW_W = 13
) (
  input logic             clk,
  input logic             rst_n,
  input logic             host_cyc,
  input logic             sd_cs_n,
  input logic             sd_ras_n,
  input logic             sd_cas_n,
  input logic             sd_we_n,
  input logic [ROW_W-1:0] sd_addr,
  input logic             sdram_ready,
  input logic             host_stall,
  input logic             refresh_overrun,
  input logic             mode_error
);
  logic is_ref, is_mrs, is_idle;
  assign is_ref  = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0001;
  assign is_mrs  = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0000;
  assign is_idle = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b1111;

  assert_addr_high_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sd_addr[ROW_W-1:12] == '0);
  assert_ref_waits_host_R7: assert property (@(posedge clk) disable iff (!rst_n)
    host_cyc |=> !is_ref);
  assert_ref_only_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    is_ref |-> sdram_ready);
  assert_stall_on_ref_R8: assert property (@(posedge clk) disable iff (!rst_n)
    is_ref |-> host_stall);
  assert_quiet_after_ref_R8: assert property (@(posedge clk) disable iff (!rst_n)
    is_ref |=> is_idle);
  assert_stall_not_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !sdram_ready |-> host_stall);
  assert_ready_after_mrs_R5: assert property (@(posedge clk) disable iff (!rst_n)
    is_mrs ##1 !is_mrs |=> sdram_ready);
  assert_overrun_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_overrun |=> refresh_overrun);
  assert_error_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mode_error |=> mode_error);
endmodule

bind sdram_refresh_seq sdram_refresh_seq_chk #(.ROW_W(ROW_W)) chk_i (.*);

// File: tb/sdram_refresh_seq_tb.sv
module sdram_refresh_seq_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_wr = 1'b0, host_wr = 1'b0, host_cyc = 1'b0;
  logic [15:0] cfg_interval = '0;
  logic [3:0]  cfg_trc = '0;
  logic [23:0] host_addr = '0;
  logic sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
  logic [12:0] sd_addr;
  logic sdram_ready, host_stall, refresh_overrun, mode_error;

  sdram_refresh_seq dut_i (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, failures = 0, cyc = 0, ref_count = 0;
  bit cmp_en = 0;
  int ref_times[$];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // behavioural model
  bit m_cfg, m_pend, m_ready, m_ovr, m_err;
  int m_intv, m_trc, m_phase, m_hold, m_mrd;
  logic [3:0]  m_cmd;
  logic [12:0] m_addr;

  function automatic bit legal_mode(input int v);
    int cl;
    cl = (v >> 4) & 7;
    if ((v & 'h00F) != 0) return 0;
    if ((v & 'h180) != 0) return 0;
    if ((v & 'hC00) != 0) return 0;
    return (cl == 2 || cl == 3);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cfg = 0; m_pend = 0; m_ready = 0; m_ovr = 0; m_err = 0;
      m_intv = 0; m_trc = 4; m_phase = 0; m_hold = 0; m_mrd = 0;
      m_cmd = 4'hF; m_addr = 0;
    end else begin
      bit win, mode_ok, go_ref, tk;
      int v;
      v = host_addr[11:0];
      win = host_wr && host_addr[23:12] == 12'hFFF;
      mode_ok = win && m_cfg && legal_mode(v);
      tk = m_ready && m_intv != 0 && m_phase == m_intv - 1;
      go_ref = m_pend && m_ready && !host_cyc && m_hold == 0 && !mode_ok;
      if (win && !mode_ok) m_err = 1;
      if (tk && m_pend && !go_ref) m_ovr = 1;
      if (cfg_wr || tk) m_phase = 0;
      else if (m_ready && m_intv != 0) m_phase++;
      if (tk) m_pend = 1; else if (go_ref) m_pend = 0;
      if (go_ref) m_hold = m_trc; else if (m_hold > 0) m_hold--;
      if (mode_ok) begin m_mrd = 2; m_ready = 0; end
      else if (m_mrd > 0) begin m_mrd--; if (m_mrd == 0) m_ready = 1; end
      if (mode_ok) begin m_cmd = 4'b0000; m_addr = 13'(v); end
      else if (go_ref) begin m_cmd = 4'b0001; m_addr = 0; end
      else begin m_cmd = 4'b1111; m_addr = 0; end
      if (cfg_wr) begin
        m_cfg = 1; m_intv = cfg_interval;
        m_trc = (cfg_trc < 4) ? 4 : int'(cfg_trc);
      end
    end
  end

  function automatic bit out_is_ref();
    return {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0001;
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (cmp_en) begin
      bit exp_stall;
      exp_stall = !m_ready || m_hold > 0 || m_pend;
      check({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == m_cmd, "R7 cmd",
            {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, m_cmd);
      check(sd_addr == m_addr, "R3 addr", sd_addr, m_addr);
      check(sdram_ready == m_ready, "R5 ready", sdram_ready, m_ready);
      check(host_stall == exp_stall, "R8 stall", host_stall, exp_stall);
      check(refresh_overrun == m_ovr, "R9 overrun", refresh_overrun, m_ovr);
      check(mode_error == m_err, "R4 error", mode_error, m_err);
      if (out_is_ref()) begin ref_count++; ref_times.push_back(cyc); end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    cmp_en = 0; rst_n = 0;
    cfg_wr = 0; host_wr = 0; host_cyc = 0;
    repeat (2) @(negedge clk);
    rst_n = 1; cmp_en = 1;
  endtask

  task automatic configure(input int intv, input int trc);
    @(negedge clk);
    cfg_wr = 1; cfg_interval = 16'(intv); cfg_trc = 4'(trc);
    @(negedge clk);
    cfg_wr = 0;
  endtask

  task automatic host_write(input logic [23:0] a);
    @(negedge clk);
    host_wr = 1; host_addr = a;
    @(negedge clk);
    host_wr = 0;
  endtask

  task automatic measure_stall(input int exp, input string tag);
    int k = 0;
    while (!out_is_ref()) @(negedge clk);
    while (host_stall && k < 100) begin k++; @(negedge clk); end
    check(k == exp, tag, k, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    do_reset();
    @(negedge clk);
    check({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'hF, "R1 pins", {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 4'hF);
    check(sd_addr == 0 && !sdram_ready && host_stall && !refresh_overrun && !mode_error,
          "R1 state", {sdram_ready, host_stall, refresh_overrun, mode_error}, 4'b0100);

    host_write(24'hFFF020);
    check({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'hF, "R2 no cmd", {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 4'hF);
    check(mode_error == 1, "R2 error", mode_error, 1);

    do_reset();
    configure(40, 2);
    host_write(24'hFFF020);
    check({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'h0 && sd_addr == 13'h020, "R3 mode set", sd_addr, 13'h020);
    @(negedge clk);
    check(sdram_ready == 0, "R5 ready low", sdram_ready, 0);
    @(negedge clk);
    check(sdram_ready == 1, "R5 ready high", sdram_ready, 1);

    measure_stall(4, "R8 clamped trc");
    ref_times.delete();
    repeat (200) @(negedge clk);
    check(ref_times.size() >= 4, "R6 refresh count", ref_times.size(), 4);
    for (int i = 1; i < ref_times.size(); i++)
      check(ref_times[i] - ref_times[i-1] == 40, "R6 spacing", ref_times[i] - ref_times[i-1], 40);

    @(negedge clk); host_cyc = 1;
    repeat (15) @(negedge clk);
    host_cyc = 0;
    repeat (60) @(negedge clk);
    check(refresh_overrun == 0, "R7 short hold no overrun", refresh_overrun, 0);

    host_cyc = 1;
    repeat (100) @(negedge clk);
    check(refresh_overrun == 1, "R9 overrun set", refresh_overrun, 1);
    ref_count = 0;
    host_cyc = 0;
    repeat (12) @(negedge clk);
    check(ref_count == 1, "R9 single service", ref_count, 1);

    host_write(24'h000020);
    check({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} != 4'h0 && mode_error == 0 && sdram_ready == 1,
          "R10 outside window", {mode_error, sdram_ready}, 2'b01);

    configure(40, 15);
    measure_stall(15, "R8 trc 15");

    configure(0, 4);
    repeat (20) @(negedge clk);
    ref_count = 0;
    repeat (150) @(negedge clk);
    check(ref_count == 0, "R6 interval zero", ref_count, 0);

    do_reset();
    configure(30, 5);
    host_write(24'hFFF040);
    check({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'hF && mode_error == 1, "R4 CL4 rejected", mode_error, 1);
    host_write(24'hFFF021);
    check({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'hF, "R4 burst rejected", {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 4'hF);
    host_write(24'hFFF230);
    check({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'h0 && sd_addr == 13'h230, "R4 CL3 accepted", sd_addr, 13'h230);
    repeat (80) @(negedge clk);
    check(sdram_ready == 1, "R5 ready after CL3 set", sdram_ready, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule